// File: doc/BRIEF.md
# Tiered Code-Memory Access Guard

The guard sits between a byte-wide program memory array and two requesters. A programming port is active while `prog_mode` is high. A CPU read port is active while `prog_mode` is low. A 2-bit security level decides two things: whether program requests may change the array or the two configuration bytes, and what a read returns. A read can return the stored byte, the stored byte scrambled with a fixed key, or all ones. Level 3 is the erased, fully open state. Levels 2, 1 and 0 add restrictions step by step.

In run mode the CPU gives each read an access kind and a tag. The tag is high when the opcode now executing was fetched from the protected array. At the two strictest levels, an operand read from code that lives outside the array receives 0xFF. Opcode fetches, control transfers and interrupt vector fetches always see the true byte.

The memory is a synchronous array. It returns data one cycle after `mem_re`. A program operation is a read followed by a write-back of the old byte ANDed with the new byte, because programming can only clear bits.

Top module: `codemem_guard`

## Requirements
- R1: While reset is held, and right after it, `pp_rvalid`, `cpu_rvalid`, `pp_err`, `mem_re` and `mem_we` are low. Both configuration bytes read back as 0xFF.
- R2: At level 3 (2'b11), an array program request reads the addressed byte in its request cycle. In the next cycle it writes back (old AND new) to the same address with `mem_we` high, and raises no error.
- R3: At levels 2, 1 and 0, every program request is refused, whether it targets the array (`pp_cfg`=0) or a configuration byte (`pp_cfg`=1). `pp_err` goes high for exactly the one cycle after the request, `mem_we` stays low, and the stored contents are unchanged.
- R4: In programming mode at levels 3 and 2, an array read returns the stored byte.
- R5: In programming mode at level 1, an array read returns the stored byte XOR `SCRAMBLE_KEY` (default 0xA5).
- R6: In programming mode at level 0, an array read returns 0xFF.
- R7: A configuration read (`pp_cfg`=1, byte chosen by `pp_addr[0]`) returns the stored configuration byte at every level. At level 3, programming a configuration byte leaves (old AND new).
- R8: In run mode at levels 3 and 2, every CPU read returns the stored byte, whatever its kind and tag.
- R9: In run mode at levels 1 and 0, an operand read (`cpu_kind`=2'b01) returns 0xFF when `cpu_tag` is 0, and the stored byte when `cpu_tag` is 1.
- R10: In run mode at levels 1 and 0, opcode fetches (2'b00), vector fetches (2'b10) and control-transfer reads (2'b11) return the stored byte for either tag value.
- R11: Programming-port requests have no effect in run mode, and CPU requests have no effect in programming mode. Neither raises `mem_re`, a response valid or an error.
- R12: An accepted read raises `mem_re` with `mem_addr` equal to the request address in the request cycle, and gives its response valid and data one cycle later. A request that arrives in the write-back cycle of a program operation is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_mode | input | 1 | 1 = programming mode, 0 = run mode |
| sec_level | input | 2 | Security level from configuration storage (3 = open) |
| pp_req | input | 1 | Programming-port request |
| pp_write | input | 1 | 1 = program, 0 = read |
| pp_cfg | input | 1 | 1 = target a configuration byte, 0 = the array |
| pp_addr | input | AW | Programming-port address |
| pp_wdata | input | 8 | Byte to program |
| pp_rvalid | output | 1 | Programming-port read response valid |
| pp_rdata | output | 8 | Programming-port read data |
| pp_err | output | 1 | One-cycle pulse for a refused program request |
| cpu_req | input | 1 | CPU read request |
| cpu_kind | input | 2 | 00 opcode, 01 operand, 10 vector, 11 control transfer |
| cpu_tag | input | 1 | Current opcode was fetched from the array |
| cpu_addr | input | AW | CPU address |
| cpu_rvalid | output | 1 | CPU read response valid |
| cpu_rdata | output | 8 | CPU read data |
| mem_re | output | 1 | Array read strobe |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | AW | Array address |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, valid one cycle after `mem_re` |

## Verification
The assertions check the following on every cycle:
- a write strobe is never seen without an open-level program request in the previous cycle, and a write only clears bits relative to the requested byte;
- an error pulse always traces back to a refused program request and never comes with a write;
- level 0 array reads return ones, blocked operand reads return ones, and non-operand CPU reads pass memory data through unchanged.

Other behaviour only the bench's sweeps can show. These are the exact scrambled values over the whole address range, the accumulation of AND-programming across repeated writes, the contents staying unchanged after refusals, mode gating, and the dropping of requests during write-back.

// File: rtl/cg_pkg.sv
package cg_pkg;

  localparam int CG_DW = 8;

  typedef enum logic [1:0] {
    KIND_OPCODE  = 2'b00,
    KIND_OPERAND = 2'b01,
    KIND_VECTOR  = 2'b10,
    KIND_XFER    = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    VIEW_TRUE     = 2'b00,
    VIEW_SCRAMBLE = 2'b01,
    VIEW_ONES     = 2'b10
  } view_e;

  localparam logic [1:0] LVL_OPEN = 2'b11;

  // Only the erased (open) level may program anything.
  function automatic logic prog_permitted(input logic [1:0] lvl);
    return lvl == LVL_OPEN;
  endfunction

  // How an array read on the programming port is presented.
  function automatic view_e prog_array_view(input logic [1:0] lvl);
    case (lvl)
      2'b11, 2'b10: return VIEW_TRUE;
      2'b01:        return VIEW_SCRAMBLE;
      default:      return VIEW_ONES;
    endcase
  endfunction

  // Run-mode view: operands from foreign code are hidden at strict levels.
  function automatic view_e run_view(input logic [1:0] lvl, input acc_kind_e kind,
                                     input logic opc_in_array);
    if (lvl[1])
      return VIEW_TRUE;
    if (kind == KIND_OPERAND && !opc_in_array)
      return VIEW_ONES;
    return VIEW_TRUE;
  endfunction

  function automatic logic [CG_DW-1:0] apply_view(input view_e v, input logic [CG_DW-1:0] d,
                                                  input logic [CG_DW-1:0] key);
    case (v)
      VIEW_TRUE:     return d;
      VIEW_SCRAMBLE: return d ^ key;
      default:       return '1;
    endcase
  endfunction

  // Programming can only clear bits.
  function automatic logic [CG_DW-1:0] burn(input logic [CG_DW-1:0] old_b,
                                            input logic [CG_DW-1:0] new_b);
    return old_b & new_b;
  endfunction

endpackage

// File: rtl/cg_policy.sv
module cg_policy
  import cg_pkg::*;
(
  input  logic       prog_mode,
  input  logic [1:0] sec_level,
  input  logic       pp_req,
  input  logic       pp_write,
  input  logic       pp_cfg,
  input  logic       cpu_req,
  input  logic [1:0] cpu_kind,
  input  logic       cpu_tag,
  output logic       arr_rd_pp,
  output logic       arr_wr_pp,
  output logic       cfg_rd_pp,
  output logic       cfg_wr_pp,
  output logic       refuse_pp,
  output logic       rd_cpu,
  output view_e      pp_view,
  output view_e      cpu_view
);
  logic pp_live, cpu_live, open_lvl;

  always_comb begin
    pp_live   = pp_req & prog_mode;
    cpu_live  = cpu_req & ~prog_mode;
    open_lvl  = prog_permitted(sec_level);
    arr_rd_pp = pp_live & ~pp_write & ~pp_cfg;
    cfg_rd_pp = pp_live & ~pp_write & pp_cfg;
    arr_wr_pp = pp_live & pp_write & ~pp_cfg & open_lvl;
    cfg_wr_pp = pp_live & pp_write & pp_cfg & open_lvl;
    refuse_pp = pp_live & pp_write & ~open_lvl;
    rd_cpu    = cpu_live;
    pp_view   = prog_array_view(sec_level);
    cpu_view  = run_view(sec_level, acc_kind_e'(cpu_kind), cpu_tag);
  end
endmodule

// File: rtl/cg_burn_seq.sv
module cg_burn_seq
  import cg_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    addr,
  input  logic [CG_DW-1:0] wdata,
  input  logic [CG_DW-1:0] mem_rdata,
  output logic             wb_active,
  output logic [AW-1:0]    wb_addr,
  output logic [CG_DW-1:0] wb_data
);
  logic [CG_DW-1:0] new_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_active <= 1'b0;
      wb_addr   <= '0;
      new_q     <= '0;
    end else begin
      wb_active <= start;
      if (start) begin
        wb_addr <= addr;
        new_q   <= wdata;
      end
    end
  end

  assign wb_data = burn(mem_rdata, new_q);

  // The write-back cycle never repeats: requests are gated while it runs.
  assert_wb_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wb_active |=> !wb_active);
endmodule

// File: rtl/cg_cfg_bank.sv
module cg_cfg_bank
  import cg_pkg::*;
#(
  parameter int NCFG = 2,
  localparam int SELW = (NCFG > 1) ? $clog2(NCFG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SELW-1:0]  sel,
  input  logic [CG_DW-1:0] wdata,
  output logic [CG_DW-1:0] rd_val
);
  logic [CG_DW-1:0] bank [NCFG];

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank[g] <= '1;
      else if (wr_en && int'(sel) == g)
        bank[g] <= burn(bank[g], wdata);
    end
  end

  always_comb begin
    rd_val = '1;
    for (int i = 0; i < NCFG; i++)
      if (int'(sel) == i) rd_val = bank[i];
  end
endmodule

// File: rtl/cg_resp.sv
module cg_resp
  import cg_pkg::*;
#(
  parameter logic [CG_DW-1:0] SCRAMBLE_KEY = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arr_rd_pp,
  input  logic             cfg_rd_pp,
  input  logic             refuse_pp,
  input  logic             rd_cpu,
  input  view_e            pp_view,
  input  view_e            cpu_view,
  input  logic [CG_DW-1:0] cfg_val,
  input  logic [CG_DW-1:0] mem_rdata,
  output logic             pp_rvalid,
  output logic [CG_DW-1:0] pp_rdata,
  output logic             pp_err,
  output logic             cpu_rvalid,
  output logic [CG_DW-1:0] cpu_rdata
);
  logic             from_cfg_q;
  view_e            pp_view_q, cpu_view_q;
  logic [CG_DW-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pp_rvalid  <= 1'b0;
      from_cfg_q <= 1'b0;
      pp_view_q  <= VIEW_TRUE;
      cfg_q      <= '0;
      cpu_rvalid <= 1'b0;
      cpu_view_q <= VIEW_TRUE;
      pp_err     <= 1'b0;
    end else begin
      pp_rvalid  <= arr_rd_pp | cfg_rd_pp;
      from_cfg_q <= cfg_rd_pp;
      pp_view_q  <= pp_view;
      cfg_q      <= cfg_val;
      cpu_rvalid <= rd_cpu;
      cpu_view_q <= cpu_view;
      pp_err     <= refuse_pp;
    end
  end

  always_comb begin
    pp_rdata  = '0;
    cpu_rdata = '0;
    if (pp_rvalid)
      pp_rdata = from_cfg_q ? cfg_q : apply_view(pp_view_q, mem_rdata, SCRAMBLE_KEY);
    if (cpu_rvalid)
      cpu_rdata = apply_view(cpu_view_q, mem_rdata, SCRAMBLE_KEY);
  end
endmodule

// File: rtl/codemem_guard.sv
module codemem_guard
  import cg_pkg::*;
#(
  parameter int                AW           = 14,
  parameter int                NCFG         = 2,
  parameter logic [CG_DW-1:0]  SCRAMBLE_KEY = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_mode,
  input  logic [1:0]       sec_level,
  input  logic             pp_req,
  input  logic             pp_write,
  input  logic             pp_cfg,
  input  logic [AW-1:0]    pp_addr,
  input  logic [CG_DW-1:0] pp_wdata,
  output logic             pp_rvalid,
  output logic [CG_DW-1:0] pp_rdata,
  output logic             pp_err,
  input  logic             cpu_req,
  input  logic [1:0]       cpu_kind,
  input  logic             cpu_tag,
  input  logic [AW-1:0]    cpu_addr,
  output logic             cpu_rvalid,
  output logic [CG_DW-1:0] cpu_rdata,
  output logic             mem_re,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [CG_DW-1:0] mem_wdata,
  input  logic [CG_DW-1:0] mem_rdata
);
  localparam int SELW = (NCFG > 1) ? $clog2(NCFG) : 1;

  // Named internal events for the checks below.
  logic             wb_active;
  logic [AW-1:0]    wb_addr;
  logic [CG_DW-1:0] wb_data;
  logic             arr_rd_pp, arr_wr_pp, cfg_rd_pp, cfg_wr_pp, refuse_pp, rd_cpu;
  view_e            pp_view, cpu_view;
  logic [CG_DW-1:0] cfg_val;
  logic             pp_req_g, cpu_req_g;

  // Requests landing on the write-back cycle are dropped.
  assign pp_req_g  = pp_req & ~wb_active;
  assign cpu_req_g = cpu_req & ~wb_active;

  cg_policy u_policy (
    .prog_mode (prog_mode),
    .sec_level (sec_level),
    .pp_req    (pp_req_g),
    .pp_write  (pp_write),
    .pp_cfg    (pp_cfg),
    .cpu_req   (cpu_req_g),
    .cpu_kind  (cpu_kind),
    .cpu_tag   (cpu_tag),
    .arr_rd_pp (arr_rd_pp),
    .arr_wr_pp (arr_wr_pp),
    .cfg_rd_pp (cfg_rd_pp),
    .cfg_wr_pp (cfg_wr_pp),
    .refuse_pp (refuse_pp),
    .rd_cpu    (rd_cpu),
    .pp_view   (pp_view),
    .cpu_view  (cpu_view)
  );

  cg_burn_seq #(.AW(AW)) u_burn (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (arr_wr_pp),
    .addr      (pp_addr),
    .wdata     (pp_wdata),
    .mem_rdata (mem_rdata),
    .wb_active (wb_active),
    .wb_addr   (wb_addr),
    .wb_data   (wb_data)
  );

  cg_cfg_bank #(.NCFG(NCFG)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_wr_pp),
    .sel    (pp_addr[SELW-1:0]),
    .wdata  (pp_wdata),
    .rd_val (cfg_val)
  );

  cg_resp #(.SCRAMBLE_KEY(SCRAMBLE_KEY)) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .arr_rd_pp  (arr_rd_pp),
    .cfg_rd_pp  (cfg_rd_pp),
    .refuse_pp  (refuse_pp),
    .rd_cpu     (rd_cpu),
    .pp_view    (pp_view),
    .cpu_view   (cpu_view),
    .cfg_val    (cfg_val),
    .mem_rdata  (mem_rdata),
    .pp_rvalid  (pp_rvalid),
    .pp_rdata   (pp_rdata),
    .pp_err     (pp_err),
    .cpu_rvalid (cpu_rvalid),
    .cpu_rdata  (cpu_rdata)
  );

  // Array port: write-back owns the port; otherwise the active mode's requester.
  always_comb begin
    mem_we    = wb_active;
    mem_wdata = wb_data;
    mem_re    = arr_rd_pp | arr_wr_pp | rd_cpu;
    if (wb_active)
      mem_addr = wb_addr;
    else if (prog_mode)
      mem_addr = pp_addr;
    else
      mem_addr = cpu_addr;
  end

  assert_burn_needs_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(prog_mode && pp_req && pp_write && !pp_cfg && sec_level == 2'b11));

  assert_burn_clears_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_wdata & ~$past(pp_wdata)) == '0));

  assert_refuse_no_burn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pp_err |-> !mem_we);

  assert_err_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pp_err |-> $past(prog_mode && pp_req && pp_write && sec_level != 2'b11));

  assert_lvl0_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pp_rvalid && $past(sec_level == 2'b00 && !pp_cfg)) |-> pp_rdata == '1);

  assert_operand_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rvalid && $past(!sec_level[1] && cpu_kind == KIND_OPERAND && !cpu_tag))
      |-> cpu_rdata == '1);

  assert_fetch_passes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rvalid && $past(cpu_kind != KIND_OPERAND)) |-> cpu_rdata == mem_rdata);

  assert_cpu_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> $past(!prog_mode));

  assert_port_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));
endmodule

// File: tb/codemem_guard_tb_top.sv
module codemem_guard_tb_top;
  localparam int AW = 14;
  localparam logic [7:0] KEY = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       prog_mode = 1'b1;
  logic [1:0] sec_level = 2'b11;
  logic       pp_req = 1'b0, pp_write = 1'b0, pp_cfg = 1'b0;
  logic [AW-1:0] pp_addr = '0, cpu_addr = '0;
  logic [7:0] pp_wdata = '0;
  logic       pp_rvalid, pp_err, cpu_rvalid;
  logic [7:0] pp_rdata, cpu_rdata;
  logic       cpu_req = 1'b0, cpu_tag = 1'b0;
  logic [1:0] cpu_kind = 2'b00;
  logic       mem_re, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  codemem_guard #(.AW(AW), .SCRAMBLE_KEY(KEY)) dut_i (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .sec_level(sec_level),
    .pp_req(pp_req), .pp_write(pp_write), .pp_cfg(pp_cfg), .pp_addr(pp_addr),
    .pp_wdata(pp_wdata), .pp_rvalid(pp_rvalid), .pp_rdata(pp_rdata), .pp_err(pp_err),
    .cpu_req(cpu_req), .cpu_kind(cpu_kind), .cpu_tag(cpu_tag), .cpu_addr(cpu_addr),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .mem_re(mem_re), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Small synchronous array model, indexed by the low address byte.
  logic [7:0] marr [256];
  logic [7:0] shadow [256];
  logic [7:0] rd_q = 8'h00;
  assign mem_rdata = rd_q;
  always @(posedge clk) begin
    if (mem_re) rd_q <= marr[mem_addr[7:0]];
    if (mem_we) marr[mem_addr[7:0]] <= mem_wdata;
  end

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Programming-port read: response sampled one cycle after the request.
  task automatic pp_read(input int a, input bit cfg, output logic [7:0] d, output logic v);
    @(negedge clk);
    pp_req = 1; pp_write = 0; pp_cfg = cfg; pp_addr = AW'(a);
    @(posedge clk); @(negedge clk);
    d = pp_rdata; v = pp_rvalid;
    pp_req = 0;
  endtask

  task automatic pp_prog(input int a, input bit cfg, input logic [7:0] nd,
                         output logic err, output logic we, output logic [7:0] wd);
    @(negedge clk);
    pp_req = 1; pp_write = 1; pp_cfg = cfg; pp_addr = AW'(a); pp_wdata = nd;
    @(posedge clk); @(negedge clk);
    err = pp_err; we = mem_we; wd = mem_wdata;
    pp_req = 0; pp_write = 0;
    @(posedge clk); @(negedge clk);
    chk(pp_err == 1'b0 && mem_we == 1'b0, "R3 single-cycle pulse", {pp_err, mem_we}, 0);
  endtask

  task automatic cpu_read(input int a, input logic [1:0] k, input bit t,
                          output logic [7:0] d, output logic v);
    @(negedge clk);
    cpu_req = 1; cpu_kind = k; cpu_tag = t; cpu_addr = AW'(a);
    @(posedge clk); @(negedge clk);
    d = cpu_rdata; v = cpu_rvalid;
    cpu_req = 0;
  endtask

  function automatic logic [7:0] exp_pp_arr(input logic [1:0] lvl, input logic [7:0] s);
    if (lvl == 2'd0) return 8'hFF;
    if (lvl == 2'd1) return s ^ KEY;
    return s;
  endfunction

  initial begin
    logic [7:0] d, wd, cfg_exp0, cfg_exp1, nd;
    logic v, e, w;
    for (int i = 0; i < 256; i++) begin
      marr[i] = 8'((i * 37 + 11) ^ (i >> 3));
      shadow[i] = marr[i];
    end
    cfg_exp0 = 8'hFF; cfg_exp1 = 8'hFF;

    repeat (3) @(negedge clk);
    chk(!pp_rvalid && !cpu_rvalid && !pp_err && !mem_re && !mem_we, "R1 reset outputs",
        {pp_rvalid, cpu_rvalid, pp_err, mem_re, mem_we}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!pp_rvalid && !cpu_rvalid && !pp_err && !mem_we, "R1 after reset",
        {pp_rvalid, cpu_rvalid, pp_err, mem_we}, 0);
    pp_read(0, 1, d, v); chk(v && d == 8'hFF, "R1 cfg0 erased", d, 8'hFF);
    pp_read(1, 1, d, v); chk(v && d == 8'hFF, "R1 cfg1 erased", d, 8'hFF);

    // R12: strobe and address in the request cycle.
    @(negedge clk);
    pp_req = 1; pp_write = 0; pp_cfg = 0; pp_addr = AW'(14'h2A05);
    #1 chk(mem_re && mem_addr == AW'(14'h2A05), "R12 strobe and address", mem_addr, 14'h2A05);
    @(posedge clk); @(negedge clk);
    chk(pp_rvalid && pp_rdata == shadow[5], "R12 one-cycle latency", pp_rdata, shadow[5]);
    pp_req = 0;

    // R2: programming at level 3, twice over some addresses to show accumulation.
    for (int rep = 0; rep < 2; rep++)
      for (int a = 0; a < 64; a++) begin
        nd = 8'((a * 13 + rep * 91) ^ 8'h3C);
        pp_prog(a, 0, nd, e, w, wd);
        chk(!e && w, "R2 program accepted", {e, w}, 2'b01);
        chk(wd == (shadow[a] & nd), "R2 burned value", wd, shadow[a] & nd);
        shadow[a] = shadow[a] & nd;
      end

    // R7: configuration programming at level 3 accumulates as AND.
    pp_prog(0, 1, 8'h5F, e, w, wd); cfg_exp0 &= 8'h5F;
    chk(!e && !w, "R7 cfg program no array write", {e, w}, 0);
    pp_prog(1, 1, 8'hF3, e, w, wd); cfg_exp1 &= 8'hF3;
    pp_prog(0, 1, 8'hF6, e, w, wd); cfg_exp0 &= 8'hF6;

    // R3: refusals at levels 2, 1, 0.
    for (int l = 0; l < 3; l++) begin
      sec_level = 2'(l);
      for (int a = 0; a < 8; a++) begin
        pp_prog(a * 29, 0, 8'h00, e, w, wd);
        chk(e && !w, "R3 array program refused", {e, w}, 2'b10);
      end
      pp_prog(l & 1, 1, 8'h00, e, w, wd);
      chk(e && !w, "R3 cfg program refused", {e, w}, 2'b10);
    end

    // R12: a request during write-back is dropped.
    sec_level = 2'b11;
    @(negedge clk);
    pp_req = 1; pp_write = 1; pp_cfg = 0; pp_addr = AW'(200); pp_wdata = 8'hFF;
    @(posedge clk); @(negedge clk);
    pp_write = 0; pp_addr = AW'(201);
    #1 chk(mem_we && !mem_re, "R12 write-back owns port", {mem_we, mem_re}, 2'b10);
    @(posedge clk); @(negedge clk);
    chk(!pp_rvalid, "R12 dropped request has no response", pp_rvalid, 0);
    pp_req = 0;
    @(negedge clk);

    // R4/R5/R6/R7: read sweeps at each level.
    for (int l = 3; l >= 0; l--) begin
      sec_level = 2'(l);
      for (int a = 0; a < 256; a++) begin
        pp_read(a, 0, d, v);
        if (l >= 2)
          chk(v && d == shadow[a], "R4 true read", d, shadow[a]);
        else if (l == 1)
          chk(v && d == exp_pp_arr(2'(l), shadow[a]), "R5 scrambled read", d, shadow[a] ^ KEY);
        else
          chk(v && d == 8'hFF, "R6 ones read", d, 8'hFF);
      end
      pp_read(0, 1, d, v); chk(v && d == cfg_exp0, "R7 cfg0 read", d, cfg_exp0);
      pp_read(1, 1, d, v); chk(v && d == cfg_exp1, "R7 cfg1 read", d, cfg_exp1);
    end

    // R11: CPU requests ignored in programming mode.
    cpu_read(3, 2'b00, 1, d, v);
    chk(!v && d == 8'h00, "R11 cpu ignored in prog mode", {v, d}, 0);

    // Run mode sweeps: R8, R9, R10.
    prog_mode = 0;
    for (int l = 0; l < 4; l++) begin
      sec_level = 2'(l);
      for (int k = 0; k < 4; k++)
        for (int t = 0; t < 2; t++)
          for (int a = 0; a < 256; a += 16) begin
            cpu_read(a + k + t, 2'(k), t[0], d, v);
            if (l >= 2)
              chk(v && d == shadow[a + k + t], "R8 open run read", d, shadow[a + k + t]);
            else if (k == 1 && t == 0)
              chk(v && d == 8'hFF, "R9 operand blocked", d, 8'hFF);
            else if (k == 1)
              chk(v && d == shadow[a + k + t], "R9 operand from array", d, shadow[a + k + t]);
            else
              chk(v && d == shadow[a + k + t], "R10 fetch passes", d, shadow[a + k + t]);
          end
    end

    // R11: programming-port requests ignored in run mode.
    sec_level = 2'b11;
    @(negedge clk);
    pp_req = 1; pp_write = 0; pp_cfg = 0; pp_addr = AW'(7);
    #1 chk(!mem_re, "R11 pp read no strobe in run mode", mem_re, 0);
    @(posedge clk); @(negedge clk);
    chk(!pp_rvalid, "R11 pp read no response in run mode", pp_rvalid, 0);
    pp_req = 0;
    pp_prog(7, 0, 8'h00, e, w, wd);
    chk(!e && !w, "R11 pp program ignored in run mode", {e, w}, 0);
    sec_level = 2'b00;
    pp_prog(9, 0, 8'h00, e, w, wd);
    chk(!e && !w, "R11 no error in run mode", {e, w}, 0);
    cpu_read(7, 2'b00, 0, d, v);
    chk(v && d == shadow[7], "R11 contents unchanged", d, shadow[7]);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule